// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block is a multi-cycle integer divider for a 32-bit datapath. A caller presents a 32-bit dividend, a divisor operand and two mode bits, then pulses a start strobe. The divisor is used either as a full word or as its low halfword only. In signed mode the halfword is sign-extended, and in unsigned mode it is zero-extended. Division runs on operand magnitudes, one quotient bit per clock. Signs are applied at the end, so the quotient truncates toward zero and the remainder takes the sign of the dividend.

At completion the unit drives the quotient and the remainder on two separate result ports. It also replaces three condition flags: zero, sign and overflow. All three flags are cleared and then re-evaluated on every completion. Overflow is raised for a zero divisor and for the one signed case whose quotient cannot be represented. Both cases give fixed results and take the same time as any other divide. Writing results into a register file, instruction decode and trap handling belong to the surrounding pipeline.

Top module: `div_flag_unit`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, quot_o, rem_o, flag_z_o, flag_s_o and flag_ov_o are all 0.
- R2: A start_i sampled high at a rising edge while busy_o is low is accepted. busy_o is 1 from the next cycle. done_o rises after the 32nd rising edge following the accepting edge, stays high for exactly one cycle, and is never high together with busy_o.
- R3: With signed_i=1 and half_i=0, both operands are two's complement words. The quotient truncates toward zero and the remainder has the sign of the dividend (zero remainder excepted).
- R4: With signed_i=0 and half_i=0, both operands are unsigned words and the results are the unsigned quotient and remainder.
- R5: With signed_i=1 and half_i=1, the divisor is divisor_i[15:0] sign-extended to 32 bits, and divisor_i[31:16] has no effect.
- R6: With signed_i=0 and half_i=1, the divisor is divisor_i[15:0] zero-extended to 32 bits, and divisor_i[31:16] has no effect.
- R7: If the extended divisor is zero, the completion gives quot_o=0, rem_o=0, flag_ov_o=1, flag_z_o=1 and flag_s_o=0.
- R8: In signed mode, a dividend of 0x80000000 divided by an extended divisor of 0xFFFFFFFF gives quot_o=0x80000000, rem_o=0, flag_ov_o=1 and flag_s_o=1.
- R9: At every completion all three flags are replaced. flag_z_o is 1 exactly when quot_o is 0, and flag_ov_o is 0 unless R7 or R8 applies.
- R10: flag_s_o equals bit 31 of quot_o at every completion. In signed mode this marks a negative quotient.
- R11: A start_i asserted while busy_o is 1 is ignored: neither the running result nor its completion cycle changes.
- R12: quot_o, rem_o and the flags hold their values from one completion to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| half_i | input | 1 | 1 = use low halfword of divisor_i |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor operand before extension |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient |
| rem_o | output | 32 | Remainder |
| flag_z_o | output | 1 | Quotient is zero |
| flag_s_o | output | 1 | Quotient bit 31 |
| flag_ov_o | output | 1 | Divide by zero or unrepresentable quotient |

## Verification
busy_o is due one cycle after the accepting edge. The results, the flags and done_o are all due together after the 32nd following rising edge, and done_o must be low again one cycle later. The bench drives and samples on falling edges. It watches busy_o and done_o on each of the 31 intermediate cycles to catch an early finish, then compares every result on the falling edge right after the 32nd iteration edge, and checks that the results still hold one cycle later. The ignored-start scenario issues a second start mid-run and keeps the same cycle count measured from the first start.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic neg_q;     // quotient magnitude must be negated
    logic neg_r;     // remainder magnitude must be negated
    logic div_zero;  // extended divisor is zero
    logic min_ovf;   // signed most-negative / -1
  } div_ctl_t;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep import div_pkg::*; #(
  parameter int W = 32,
  parameter int H = 16
) (
  input  logic         signed_i,
  input  logic         half_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output div_ctl_t     ctl_o
);
  localparam logic [W-1:0] MinVal = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ext_b;
  logic         a_neg, b_neg;

  always_comb begin
    if (half_i) ext_b = {{(W-H){signed_i & divisor_i[H-1]}}, divisor_i[H-1:0]};
    else        ext_b = divisor_i;
  end

  assign a_neg   = signed_i & dividend_i[W-1];
  assign b_neg   = signed_i & ext_b[W-1];
  assign mag_a_o = a_neg ? (~dividend_i + 1'b1) : dividend_i;
  assign mag_b_o = b_neg ? (~ext_b + 1'b1) : ext_b;

  assign ctl_o.neg_q    = a_neg ^ b_neg;
  assign ctl_o.neg_r    = a_neg;
  assign ctl_o.div_zero = (ext_b == '0);
  assign ctl_o.min_ovf  = signed_i && (dividend_i == MinVal) && (&ext_b);
endmodule

// File: rtl/div_restore_core.sv
module div_restore_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic         busy_o,
  output logic         last_o,
  output logic [W-1:0] quo_nxt_o,
  output logic [W-1:0] rem_nxt_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  part_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, diff;
  logic          fits;

  assign shifted   = {part_q, quo_q[W-1]};
  assign fits      = shifted >= {1'b0, dsr_q};
  assign diff      = shifted - {1'b0, dsr_q};
  assign rem_nxt_o = fits ? diff[W-1:0] : shifted[W-1:0];
  assign quo_nxt_o = {quo_q[W-2:0], fits};
  assign last_o    = busy_o && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (busy_o) begin
      part_q <= rem_nxt_o;
      quo_q  <= quo_nxt_o;
      cnt_q  <= cnt_q - 1'b1;
      if (last_o) busy_o <= 1'b0;
    end else if (load_i) begin
      part_q <= '0;
      quo_q  <= mag_a_i;
      dsr_q  <= mag_b_i;
      cnt_q  <= CW'(W);
      busy_o <= 1'b1;
    end
  end
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix import div_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] mag_q_i,
  input  logic [W-1:0] mag_r_i,
  input  div_ctl_t     ctl_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         z_o,
  output logic         s_o,
  output logic         ov_o
);
  always_comb begin
    quot_o = ctl_i.neg_q ? (~mag_q_i + 1'b1) : mag_q_i;
    rem_o  = ctl_i.neg_r ? (~mag_r_i + 1'b1) : mag_r_i;
    ov_o   = 1'b0;
    if (ctl_i.div_zero) begin
      quot_o = '0;
      rem_o  = '0;
      ov_o   = 1'b1;
    end else if (ctl_i.min_ovf) begin
      quot_o = {1'b1, {(W-1){1'b0}}};
      rem_o  = '0;
      ov_o   = 1'b1;
    end
    z_o = (quot_o == '0);
    s_o = quot_o[W-1];
  end
endmodule

// File: rtl/div_flag_unit.sv
module div_flag_unit import div_pkg::*; #(
  parameter int W = 32,
  parameter int H = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic         half_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         flag_z_o,
  output logic         flag_s_o,
  output logic         flag_ov_o
);
  logic [W-1:0] mag_a, mag_b, quo_nxt, rem_nxt, fix_q, fix_r;
  div_ctl_t     ctl_in, ctl_q;
  logic         last, accept, fz, fs, fov;

  assign accept = start_i && !busy_o;

  div_operand_prep #(.W(W), .H(H)) u_prep (
    .signed_i(signed_i), .half_i(half_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .mag_a_o(mag_a), .mag_b_o(mag_b), .ctl_o(ctl_in)
  );

  div_restore_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .mag_a_i(mag_a), .mag_b_i(mag_b),
    .busy_o(busy_o), .last_o(last),
    .quo_nxt_o(quo_nxt), .rem_nxt_o(rem_nxt)
  );

  div_result_fix #(.W(W)) u_fix (
    .mag_q_i(quo_nxt), .mag_r_i(rem_nxt), .ctl_i(ctl_q),
    .quot_o(fix_q), .rem_o(fix_r), .z_o(fz), .s_o(fs), .ov_o(fov)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= '0;
      done_o    <= 1'b0;
      quot_o    <= '0;
      rem_o     <= '0;
      flag_z_o  <= 1'b0;
      flag_s_o  <= 1'b0;
      flag_ov_o <= 1'b0;
    end else begin
      if (accept) ctl_q <= ctl_in;
      done_o <= last;
      if (last) begin
        quot_o    <= fix_q;
        rem_o     <= fix_r;
        flag_z_o  <= fz;
        flag_s_o  <= fs;
        flag_ov_o <= fov;
      end
    end
  end
endmodule

// File: rtl/div_flag_unit_chk.sv
module div_flag_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quot_o,
  input logic [W-1:0] rem_o,
  input logic         flag_z_o,
  input logic         flag_s_o,
  input logic         flag_ov_o
);
  localparam int CW = $clog2(W + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_cnt <= '0;
    else if (start_i && !busy_o) run_cnt <= '0;
    else if (busy_o)             run_cnt <= run_cnt + 1'b1;
  end

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);                                            // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                            // R2
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);                               // R2
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_cnt == CW'(W));                                  // R2
  AST_OVF_REM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_ov_o) |-> rem_o == '0);                         // R7
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_z_o == (quot_o == '0));                         // R9
  AST_SIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_s_o == quot_o[W-1]);                            // R10
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(flag_z_o)
                 && $stable(flag_s_o) && $stable(flag_ov_o)));      // R12
endmodule

bind div_flag_unit div_flag_unit_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o), .flag_z_o(flag_z_o),
  .flag_s_o(flag_s_o), .flag_ov_o(flag_ov_o)
);

// File: tb/sim_div_flag_unit.sv
`timescale 1ns/1ps
module sim_div_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0, half = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done, fz, fs, fov;
  logic [31:0] quot, rem;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  div_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn), .half_i(half),
    .dividend_i(a), .divisor_i(b), .busy_o(busy), .done_o(done),
    .quot_o(quot), .rem_o(rem), .flag_z_o(fz), .flag_s_o(fs), .flag_ov_o(fov)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] x, input logic [31:0] y, input logic sg,
                       input logic hf, output logic [31:0] eq, output logic [31:0] er,
                       output logic ez, output logic es, output logic eo);
    logic [31:0] d;
    if (hf) d = sg ? {{16{y[15]}}, y[15:0]} : {16'h0, y[15:0]};
    else    d = y;
    eo = 1'b0;
    if (d == 0) begin eq = 0; er = 0; eo = 1'b1; end
    else if (sg && x == 32'h8000_0000 && d == 32'hFFFF_FFFF) begin
      eq = 32'h8000_0000; er = 0; eo = 1'b1;
    end else if (sg) begin
      eq = $signed(x) / $signed(d);
      er = $signed(x) % $signed(d);
    end else begin
      eq = x / d;
      er = x % d;
    end
    ez = (eq == 0);
    es = eq[31];
  endtask

  task automatic run_op(input string req, input logic [31:0] x, input logic [31:0] y,
                        input logic sg, input logic hf);
    logic [31:0] eq, er;
    logic ez, es, eo, early;
    model(x, y, sg, hf, eq, er, ez, es, eo);
    @(negedge clk);
    a = x; b = y; sgn = sg; half = hf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", {31'b0, busy}, 32'd1);
    early = 1'b0;
    for (int i = 1; i <= 31; i++) begin
      @(negedge clk);
      if (done || !busy) early = 1'b1;
    end
    check("R2", "early finish", {31'b0, early}, 32'd0);
    @(negedge clk);
    check("R2", "done/busy at 32", {30'b0, done, busy}, 32'd2);
    check(req, "quotient", quot, eq);
    check(req, "remainder", rem, er);
    check(req, "flags z/s/ov", {29'b0, fz, fs, fov}, {29'b0, ez, es, eo});
    @(negedge clk);
    check("R2", "done one cycle", {31'b0, done}, 32'd0);
    check("R12", "quotient held", quot, eq);
  endtask

  task automatic t_reset;
    check("R1", "outputs in reset", {busy, done, fz, fs, fov}, 32'd0);
    check("R1", "quot in reset", quot, 32'd0);
    check("R1", "rem in reset", rem, 32'd0);
  endtask

  task automatic t_word_signed;
    run_op("R3", 32'd100, 32'd7, 1'b1, 1'b0);
    run_op("R3", -32'sd100, 32'd7, 1'b1, 1'b0);
    run_op("R3", 32'd100, -32'sd7, 1'b1, 1'b0);
    run_op("R3", -32'sd100, -32'sd7, 1'b1, 1'b0);
  endtask

  task automatic t_word_unsigned;
    run_op("R4", 32'hFFFF_FFFF, 32'd3, 1'b0, 1'b0);
    run_op("R10", 32'hF000_0000, 32'd1, 1'b0, 1'b0);
    run_op("R4", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_half;
    run_op("R5", 32'd100, 32'h1234_FFF9, 1'b1, 1'b1);
    run_op("R5", 32'hFFFF_FF00, 32'h7FFF_0010, 1'b1, 1'b1);
    run_op("R6", 32'd100, 32'hABCD_0007, 1'b0, 1'b1);
    run_op("R6", 32'h0012_3456, 32'h0000_FFF9, 1'b0, 1'b1);
  endtask

  task automatic t_special;
    run_op("R7", 32'd1234, 32'd0, 1'b1, 1'b0);
    run_op("R7", 32'd1234, 32'hFFFF_0000, 1'b0, 1'b1);
    run_op("R8", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
    run_op("R8", 32'h8000_0000, 32'h0000_FFFF, 1'b1, 1'b1);
    run_op("R9", 32'd5, 32'd9, 1'b1, 1'b0);
  endtask

  task automatic t_ignore_start;
    @(negedge clk);
    a = 32'd1000; b = 32'd10; sgn = 1'b0; half = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 31; i++) begin
      @(negedge clk);
      if (i == 10) begin start = 1'b1; a = 32'd77; b = 32'd2; end
      if (i == 11) start = 1'b0;
    end
    @(negedge clk);
    check("R11", "done at 32 from first start", {31'b0, done}, 32'd1);
    check("R11", "quotient of first op", quot, 32'd100);
    check("R11", "remainder of first op", rem, 32'd0);
    @(negedge clk);
    check("R11", "no second run", {30'b0, busy, done}, 32'd0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_word_signed();
    t_word_unsigned();
    t_half();
    t_special();
    t_ignore_start();
    finish_run();
  end
endmodule